// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block collects interrupt request lines into a latch register, keeps a record of which service levels are currently active in a pending register, and tells the core when a latched level outranks the level being serviced. A lower level index means higher priority. The core answers a take request with an accept strobe. The block then moves the winning level from the latch register into the pending register.

Nesting is governed by one dedicated pending bit, index 4, that acts as a global disable. An accept sets it, so a new handler starts with interrupts blocked. When the handler has saved its return address, it sends a push strobe, which clears the bit and lets strictly higher-priority levels preempt it. A pop strobe, sent when the return address is restored, sets the bit again. The final return strobe clears both the serviced level's bit and the disable bit.

The serviced level is the lowest-index set pending bit at index 5 or above. Pending bit 15 comes out of reset set and stands for the idle base level.

Top module: `nip_ctrl`

## Requirements
- R1: A high `irq_req[n]` for n in 5..15 sets `latch_q[n]` at the next edge. The bit then holds until level n is accepted. If an accept of level n and a new request on level n arrive in the same cycle, `latch_q[n]` stays set.
- R2: `ack_take` while `take_req` is high clears `latch_q[take_lvl]` and sets both `pend_q[take_lvl]` and `pend_q[4]` at the next edge. `ack_take` while `take_req` is low changes nothing.
- R3: While `pend_q[4]` is set, `take_req` stays low whatever is latched.
- R4: `ret_push` clears `pend_q[4]` at the next edge. From then on, `take_req` is high only if the selected level index is strictly lower than the serviced level index.
- R5: `ret_pop` sets `pend_q[4]` at the next edge.
- R6: `ret_done` clears, at the next edge, `pend_q[4]` and the pending bit of the serviced level (the lowest-index set pending bit at index 5 or above). No other pending bit changes.
- R7: When several latch bits are set, `take_lvl` gives the lowest set index.
- R8: `latch_q[4:0]` and `pend_q[3:0]` always read zero, and requests on lines 0..4 have no effect.
- R9: After reset, `latch_q` is 0x0000, `pend_q` is 0x8000 and `take_req` is low.
- R10: Starting from latch 0x0100 and pending 0x8000, the sequence accept, push, pop, return gives pending 0x8110, 0x8100, 0x8110, 0x8000, and the latch register ends at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Interrupt request lines, one per level |
| ack_take | input | 1 | Core accepts the offered level |
| ret_push | input | 1 | Return address has been saved |
| ret_pop | input | 1 | Return address has been restored |
| ret_done | input | 1 | Return from interrupt |
| latch_q | output | 16 | Latch register |
| pend_q | output | 16 | Pending register |
| take_req | output | 1 | A latched level may be taken |
| take_lvl | output | 4 | Index of the selected latched level |

## Verification
The assertions assume the core sends at most one of the four handshake strobes in any cycle. They also assume a push, pop or return arrives only while a handler is active. The bench drives every strobe as a single-cycle pulse on its own. It sends push, pop and return only after an accept and before the matching return. The pairwise sweep resets the block between pairs, so each pair starts from the idle base level.

// File: rtl/nip_pkg.sv
package nip_pkg;
  parameter int NIP_LEVELS = 16;
  parameter int GATE_IDX   = 4;
  parameter int FIRST_LVL  = 5;
  localparam int LVL_W     = $clog2(NIP_LEVELS);

  typedef logic [NIP_LEVELS-1:0] lvl_vec_t;
  typedef logic [LVL_W:0]        lvl_idx_t;   // one extra bit: NIP_LEVELS means "none"

  // Lowest set bit at index >= from, or NIP_LEVELS when there is none.
  function automatic lvl_idx_t lowest_set(input lvl_vec_t v, input int from);
    lvl_idx_t r;
    r = lvl_idx_t'(NIP_LEVELS);
    for (int i = NIP_LEVELS - 1; i >= 0; i--) begin
      if (i >= from && v[i]) r = lvl_idx_t'(i);
    end
    return r;
  endfunction

  // One-hot vector for a level index; all zero for the "none" index.
  function automatic lvl_vec_t onehot_of(input lvl_idx_t idx);
    lvl_vec_t r;
    r = '0;
    for (int i = 0; i < NIP_LEVELS; i++) begin
      if (idx == lvl_idx_t'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

  // Mask with every bit at index >= from set.
  function automatic lvl_vec_t mask_from(input int from);
    lvl_vec_t r;
    for (int i = 0; i < NIP_LEVELS; i++) r[i] = (i >= from);
    return r;
  endfunction
endpackage

// File: rtl/nip_latch.sv
module nip_latch
  import nip_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_vec_t irq_req,
  input  lvl_vec_t clr_onehot,
  output lvl_vec_t latch_q
);
  localparam lvl_vec_t REQ_MASK = mask_from(FIRST_LVL);

  lvl_vec_t latch_d;
  lvl_vec_t req_hit;

  assign req_hit = irq_req & REQ_MASK;
  // A new request wins over a same-cycle clear, so it is never lost.
  assign latch_d = (latch_q & ~clr_onehot) | req_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  // R1: a latched bit drops only when that level is cleared by an accept
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(latch_q) & ~$past(clr_onehot)) & ~latch_q) == '0));
  // R1: a request on a usable line is visible after one edge
  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_req) & REQ_MASK) & ~latch_q) == '0));
  // R8: reserved latch bits stay zero
  p_rsvd_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~REQ_MASK) == '0);
endmodule

// File: rtl/nip_pending.sv
module nip_pending
  import nip_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_fire,
  input  lvl_vec_t acc_onehot,
  input  logic     ret_push,
  input  logic     ret_pop,
  input  logic     ret_done,
  output lvl_vec_t pend_q,
  output lvl_idx_t serv_lvl
);
  localparam lvl_vec_t GATE_BIT  = lvl_vec_t'(1) << GATE_IDX;
  localparam lvl_vec_t BASE_BIT  = lvl_vec_t'(1) << (NIP_LEVELS - 1);
  localparam lvl_vec_t PEND_MASK = mask_from(FIRST_LVL) | GATE_BIT;

  lvl_vec_t pend_d;
  lvl_vec_t serv_onehot;
  logic     ret_fire, pop_fire, push_fire;

  assign serv_lvl    = lowest_set(pend_q, FIRST_LVL);
  assign serv_onehot = onehot_of(serv_lvl);

  // Strobe priority when several collide: accept, return, pop, push.
  assign ret_fire  = ret_done & ~acc_fire;
  assign pop_fire  = ret_pop  & ~acc_fire & ~ret_done;
  assign push_fire = ret_push & ~acc_fire & ~ret_done & ~ret_pop;

  always_comb begin
    pend_d = pend_q;
    if (acc_fire)       pend_d = pend_q | acc_onehot | GATE_BIT;
    else if (ret_fire)  pend_d = pend_q & ~serv_onehot & ~GATE_BIT;
    else if (pop_fire)  pend_d = pend_q | GATE_BIT;
    else if (push_fire) pend_d = pend_q & ~GATE_BIT;
    pend_d = pend_d & PEND_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= BASE_BIT;
    else        pend_q <= pend_d;
  end

  // R2: accept marks the level active and closes the gate
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> ((pend_q & ($past(acc_onehot) | GATE_BIT)) == ($past(acc_onehot) | GATE_BIT)));
  // R4: push opens the gate
  p_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> !pend_q[GATE_IDX]);
  // R5: pop closes the gate
  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> pend_q[GATE_IDX]);
  // R6: return drops the serviced level and the gate, nothing else
  p_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (pend_q == ($past(pend_q) & ~$past(serv_onehot) & ~GATE_BIT)));
  // R8: reserved pending bits stay zero
  p_rsvd_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[GATE_IDX-1:0] == '0);
  // Input rule: at most one handshake strobe per cycle
  p_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_fire, ret_push, ret_pop, ret_done}));
endmodule

// File: rtl/nip_select.sv
module nip_select
  import nip_pkg::*;
(
  input  lvl_vec_t          latch_q,
  input  logic              gate_closed,
  input  lvl_idx_t          serv_lvl,
  output logic              take_req,
  output logic [LVL_W-1:0]  take_lvl,
  output lvl_vec_t          take_onehot
);
  lvl_idx_t best;

  assign best        = lowest_set(latch_q, 0);
  assign take_req    = (latch_q != '0) && !gate_closed && (best < serv_lvl);
  assign take_lvl    = best[LVL_W-1:0];
  assign take_onehot = onehot_of(best);

  // R3: a closed gate blocks any take
  p_gate_r3: assert final (!(gate_closed && take_req));
  // R4: only strictly higher priority than the serviced level is offered
  p_outrank_r4: assert final (!take_req || ({1'b0, take_lvl} < serv_lvl));
  // R7: no latched bit below the selected index
  p_lowest_r7: assert final (!take_req || ((latch_q & ((lvl_vec_t'(1) << take_lvl) - 1'b1)) == '0));
endmodule

// File: rtl/nip_ctrl.sv
module nip_ctrl
  import nip_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NIP_LEVELS-1:0] irq_req,
  input  logic                  ack_take,
  input  logic                  ret_push,
  input  logic                  ret_pop,
  input  logic                  ret_done,
  output logic [NIP_LEVELS-1:0] latch_q,
  output logic [NIP_LEVELS-1:0] pend_q,
  output logic                  take_req,
  output logic [LVL_W-1:0]      take_lvl
);
  lvl_vec_t take_onehot;
  lvl_vec_t acc_onehot;
  lvl_idx_t serv_lvl;
  logic     acc_fire;

  // An accept counts only while a take is being offered.
  assign acc_fire   = ack_take & take_req;
  assign acc_onehot = take_onehot & {NIP_LEVELS{acc_fire}};

  nip_latch u_latch (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .clr_onehot(acc_onehot), .latch_q(latch_q)
  );

  nip_pending u_pend (
    .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_onehot(acc_onehot),
    .ret_push(ret_push), .ret_pop(ret_pop), .ret_done(ret_done),
    .pend_q(pend_q), .serv_lvl(serv_lvl)
  );

  nip_select u_sel (
    .latch_q(latch_q), .gate_closed(pend_q[GATE_IDX]), .serv_lvl(serv_lvl),
    .take_req(take_req), .take_lvl(take_lvl), .take_onehot(take_onehot)
  );

  // R2: an accept removes the level from the latch unless re-requested
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !irq_req[take_lvl]) |=> !latch_q[$past(take_lvl)]);
  // R2: ack without an offer leaves both registers unchanged
  p_noack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !take_req && !ret_push && !ret_pop && !ret_done && irq_req == '0)
      |=> ($stable(latch_q) && $stable(pend_q)));
endmodule

// File: tb/nip_ctrl_tb_top.sv
`timescale 1ns/1ps
module nip_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_req;
  logic        ack_take, ret_push, ret_pop, ret_done;
  logic [15:0] latch_q, pend_q;
  logic        take_req;
  logic [3:0]  take_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nip_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack_take(ack_take),
    .ret_push(ret_push), .ret_pop(ret_pop), .ret_done(ret_done),
    .latch_q(latch_q), .pend_q(pend_q), .take_req(take_req), .take_lvl(take_lvl)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Inputs set after a falling edge, results read at the next falling edge.
  task automatic idle();
    irq_req = '0; ack_take = 0; ret_push = 0; ret_pop = 0; ret_done = 0;
  endtask
  task automatic tick();
    @(negedge clk);
    idle();
  endtask
  task automatic do_reset();
    idle();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask
  task automatic req(input logic [15:0] v); irq_req = v; tick(); endtask
  task automatic acc();  ack_take = 1; tick(); endtask
  task automatic push(); ret_push = 1; tick(); endtask
  task automatic pop();  ret_pop  = 1; tick(); endtask
  task automatic ret();  ret_done = 1; tick(); endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9 reset state
    chk("R9 latch", latch_q, 16'h0000);
    chk("R9 pend", pend_q, 16'h8000);
    chk("R9 take", take_req, 0);

    // R10 worked sequence
    req(16'h0100);
    chk("R10 latch", latch_q, 16'h0100);
    chk("R1 take", take_req, 1);
    chk("R7 lvl", take_lvl, 8);
    acc();
    chk("R10 acc latch", latch_q, 16'h0000);
    chk("R10 acc pend", pend_q, 16'h8110);
    req(16'h0040);
    chk("R3 gate blocks", take_req, 0);
    push();
    chk("R10 push pend", pend_q, 16'h8100);
    chk("R4 outrank take", take_req, 1);
    pop();
    chk("R10 pop pend", pend_q, 16'h8110);
    chk("R5 blocked", take_req, 0);
    ret();
    chk("R10 ret pend", pend_q, 16'h8000);
    chk("R6 latch kept", latch_q, 16'h0040);

    // R8 reserved lines
    do_reset();
    req(16'h001F);
    chk("R8 latch", latch_q, 16'h0000);
    chk("R8 take", take_req, 0);
    // R2 ack without an offer
    acc();
    chk("R2 noack pend", pend_q, 16'h8000);
    chk("R8 pend", pend_q & 16'h000F, 0);

    // R7 several latched
    req(16'hA0C0);
    chk("R7 lvl", take_lvl, 6);
    // R1 accept and same-level request together
    irq_req = 16'h0040; ack_take = 1; tick();
    chk("R1 same-cycle latch", latch_q, 16'hA0C0);
    chk("R2 pend", pend_q, 16'h8050);
    push();
    chk("R1 hold lvl", take_lvl, 6);
    chk("R4 equal level not taken", take_req, 0);
    ret();
    chk("R6 nested ret", pend_q, 16'h8000);

    // R4/R6 pairwise sweep: serviced a, requested b
    for (int a = 5; a <= 14; a++) begin
      for (int b = 5; b <= 15; b++) begin
        int ea;
        ea = 16'h8000 | (1 << a);
        do_reset();
        req(16'(1 << a));
        acc();
        push();
        chk("R4 sweep pend", pend_q, ea);
        req(16'(1 << b));
        chk("R4 sweep take", take_req, (b < a) ? 1 : 0);
        if (b < a) begin
          chk("R7 sweep lvl", take_lvl, b);
          acc();
          chk("R2 sweep pend", pend_q, ea | (1 << b) | 16'h0010);
          chk("R2 sweep latch", latch_q, 0);
          ret();
          chk("R6 sweep pend", pend_q, ea);
        end
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule